// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter serving four analog input channels. A conversion is requested either by a write to the control register that sets its start bit or by a one-clock pulse on an external trigger pin. The sequencer then spends one clock sampling. It resolves the code one bit per clock, most significant bit first. For each bit it drives a trial code to an external DAC and reads back an external comparator.

When the last bit is resolved, the code lands in the data register of the channel that was selected. A done flag is raised, and an interrupt is asserted if interrupts are enabled. The start bit reads 1 for the whole conversion and drops by itself when the conversion ends or is aborted. Only single conversions are supported. The scan-mode bit of the control register is reserved.

Top module: `sar_seq`

## Requirements
- R1: Conversion takes one sample clock followed by one clock per bit, MSB first. In a bit clock, `dac_code` equals the bits already kept OR the current bit. The current bit is kept only when `cmp_in` is 1 (input at or above the DAC). Outside bit clocks `dac_code` is 0. With an ideal comparator the result equals the analog value.
- R2: A conversion starts when the sequencer is idle and, on a clock edge, either a control write has bit 0 (start) = 1 or `trig_in` = 1. Control bit 0 reads 1 from that edge until the completing edge, which is the 11th clock edge after the starting edge. After the completing edge it reads 0.
- R3: In single mode exactly one conversion is made, and then the block stays idle with `dac_code` = 0 until a new start.
- R4: The result is written into the data register of the channel held in control bits 5:4. It is read on `rd_data` by setting `rd_sel` to the channel number.
- R5: Data registers of channels that were not converted keep their contents.
- R6: Control bit 1 (done) is set on completion. A control write with bit 1 = 0 clears it, and writing 1 has no effect. When a completion and a clearing write fall on the same edge, done stays set.
- R7: `irq` is high exactly while done = 1 and control bit 2 (interrupt enable) = 1. Clearing either bit drops it.
- R8: A control write with bit 0 = 0 during a conversion, on an edge other than the completing one, aborts the conversion. No data register changes, done is not set, and bit 0 reads 0.
- R9: While a conversion runs, writes to the channel field, further start writes and trigger pulses have no effect. When idle, a single write may change the channel and set start together, and the new channel is the one converted.
- R10: Control bit 3 (scan mode) is reserved. It always reads 0 and a write of 1 to it has no effect.
- R11: After reset the control register, all data registers, `irq` and `dac_code` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data: [0] start, [1] done, [2] irq enable, [3] reserved mode, [5:4] channel |
| ctl_rdata | output | 6 | Control register readback, same layout |
| trig_in | input | 1 | External start trigger, sampled each clock |
| cmp_in | input | 1 | Comparator result: 1 when analog input >= DAC output |
| dac_code | output | 10 | Trial code to the DAC |
| rd_sel | input | 2 | Data register select (channel number) |
| rd_data | output | 10 | Selected channel's data register |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
Two events can land on the same edge: a software write that clears the done flag, or writes 0 to start, and the hardware completion that sets done. The bench provokes this by counting clocks from the start write, so that a control write of 0x04 hits exactly the 11th edge. It then expects done to read 1, the result to be stored in the channel register and `irq` to be high. A second collision case, a start-0 write in mid conversion, must abort without touching done or the data registers.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_BIT    = 2'd2
  } sar_state_t;

  // control register bit positions
  localparam int CTL_START = 0;
  localparam int CTL_DONE  = 1;
  localparam int CTL_IEN   = 2;
  localparam int CTL_MODE  = 3;
  localparam int CTL_CH    = 4;

endpackage

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           abort,
  input  logic           cmp_in,
  output logic           busy,
  output logic           conv_done,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] result
);

  localparam int IDXW = (RES > 1) ? $clog2(RES) : 1;

  sar_state_t      st_q;
  logic [IDXW-1:0] idx_q;
  logic [RES-1:0]  acc_q;
  logic            last_bit;

  // trial code: kept bits with the bit under test forced high
  function automatic logic [RES-1:0] trial_code(input logic [RES-1:0] kept,
                                                input logic [IDXW-1:0] pos);
    logic [RES-1:0] t;
    t      = kept;
    t[pos] = 1'b1;
    return t;
  endfunction

  // decision: bit under test takes the comparator value
  function automatic logic [RES-1:0] keep_bit(input logic [RES-1:0] kept,
                                              input logic [IDXW-1:0] pos,
                                              input logic            cmp);
    logic [RES-1:0] t;
    t      = kept;
    t[pos] = cmp;
    return t;
  endfunction

  assign last_bit  = (st_q == ST_BIT) && (idx_q == '0);
  assign conv_done = last_bit;
  assign busy      = (st_q != ST_IDLE);
  assign dac_code  = (st_q == ST_BIT) ? trial_code(acc_q, idx_q) : '0;
  assign result    = keep_bit(acc_q, idx_q, cmp_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      acc_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            st_q  <= ST_SAMPLE;
            acc_q <= '0;
          end
        end
        ST_SAMPLE: begin
          if (abort) begin
            st_q <= ST_IDLE;
          end else begin
            st_q  <= ST_BIT;
            idx_q <= IDXW'(RES - 1);
          end
        end
        ST_BIT: begin
          if (last_bit) begin
            st_q  <= ST_IDLE;
            acc_q <= result;
          end else if (abort) begin
            st_q <= ST_IDLE;
          end else begin
            acc_q <= result;
            idx_q <= idx_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SAMPLE && !abort) |=> dac_code == (RES'(1) << (RES - 1)));

  assert_bit_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BIT && !last_bit && !abort) |=> acc_q[$past(idx_q)] == $past(cmp_in));

  assert_single_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !busy);

  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy && !conv_done) |=> !busy);

endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int RES = 10,
  parameter int NCH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CTL_CH+$clog2(NCH)-1:0] wdata,
  input  logic                          trig,
  input  logic                          busy,
  input  logic                          conv_done,
  input  logic [RES-1:0]                result,
  input  logic [$clog2(NCH)-1:0]        rd_sel,
  output logic                          go,
  output logic                          abort,
  output logic [CTL_CH+$clog2(NCH)-1:0] ctl_rdata,
  output logic [RES-1:0]                rd_data,
  output logic                          irq
);

  localparam int CHW = $clog2(NCH);

  logic [CHW-1:0] ch_q;
  logic           ien_q;
  logic           done_q;
  logic [RES-1:0] data_q [NCH];

  assign go    = !busy && (trig || (we && wdata[CTL_START]));
  assign abort = busy && we && !wdata[CTL_START] && !conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (we && !busy) ch_q <= wdata[CTL_CH +: CHW];
      if (we) ien_q <= wdata[CTL_IEN];
      if (conv_done)                   done_q <= 1'b1;
      else if (we && !wdata[CTL_DONE]) done_q <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               data_q[gi] <= '0;
      else if (conv_done && ch_q == CHW'(gi))   data_q[gi] <= result;
    end

    assert_keep_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_done && ch_q == CHW'(gi)) |=> $stable(data_q[gi]));
  end

  always_comb begin
    ctl_rdata                = '0;
    ctl_rdata[CTL_START]     = busy;
    ctl_rdata[CTL_DONE]      = done_q;
    ctl_rdata[CTL_IEN]       = ien_q;
    ctl_rdata[CTL_MODE]      = 1'b0;
    ctl_rdata[CTL_CH +: CHW] = ch_q;
  end

  assign rd_data = data_q[rd_sel];
  assign irq     = done_q && ien_q;

  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_q);

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[CTL_DONE] && !conv_done) |=> !done_q);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (we ? wdata[CTL_IEN] : ien_q)) |=> irq);

  assert_ch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ch_q));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES = 10,
  parameter int NCH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctl_we,
  input  logic [CTL_CH+$clog2(NCH)-1:0] ctl_wdata,
  output logic [CTL_CH+$clog2(NCH)-1:0] ctl_rdata,
  input  logic                          trig_in,
  input  logic                          cmp_in,
  output logic [RES-1:0]                dac_code,
  input  logic [$clog2(NCH)-1:0]        rd_sel,
  output logic [RES-1:0]                rd_data,
  output logic                          irq
);

  logic           go;
  logic           abort;
  logic           busy;
  logic           conv_done;
  logic [RES-1:0] result;

  sar_core #(.RES(RES)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .abort     (abort),
    .cmp_in    (cmp_in),
    .busy      (busy),
    .conv_done (conv_done),
    .dac_code  (dac_code),
    .result    (result)
  );

  sar_regs #(.RES(RES), .NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctl_we),
    .wdata     (ctl_wdata),
    .trig      (trig_in),
    .busy      (busy),
    .conv_done (conv_done),
    .result    (result),
    .rd_sel    (rd_sel),
    .go        (go),
    .abort     (abort),
    .ctl_rdata (ctl_rdata),
    .rd_data   (rd_data),
    .irq       (irq)
  );

  assert_start_reads_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ctl_rdata[CTL_START]);

  assert_mode_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[CTL_MODE]);

endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;

  localparam int RES  = 10;
  localparam int NCH  = 4;
  localparam int CTLW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ctl_we = 1'b0;
  logic [CTLW-1:0] ctl_wdata = '0;
  logic [CTLW-1:0] ctl_rdata;
  logic            trig_in = 1'b0;
  logic            cmp_in;
  logic [RES-1:0]  dac_code;
  logic [1:0]      rd_sel = '0;
  logic [RES-1:0]  rd_data;
  logic            irq;
  logic [RES-1:0]  vin = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [RES-1:0] exp_data [NCH];

  always #10 clk = ~clk;

  // ideal comparator and DAC
  assign cmp_in = (vin >= dac_code);

  sar_seq #(.RES(RES), .NCH(NCH)) u_sar_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .trig_in(trig_in), .cmp_in(cmp_in),
    .dac_code(dac_code), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [CTLW-1:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    ctl_wdata = '0;
  endtask

  task automatic check_all_data(input string req);
    for (int c = 0; c < NCH; c++) begin
      rd_sel = c[1:0];
      #1;
      check(req, $sformatf("data ch%0d", c), int'(rd_data), int'(exp_data[c]));
    end
  endtask

  task automatic t_reset;
    check("R11", "ctl after reset", int'(ctl_rdata), 0);
    check("R11", "irq after reset", int'(irq), 0);
    check("R11", "dac after reset", int'(dac_code), 0);
    check_all_data("R11");
  endtask

  task automatic t_single(input int ch, input int v);
    vin = RES'(v);
    ctl_write(CTLW'((ch << 4) | 1));
    check("R2", "start bit after write", int'(ctl_rdata[0]), 1);
    check("R1", "dac in sample clock", int'(dac_code), 0);
    wait_n(1);
    check("R1", "msb trial", int'(dac_code), 512);
    wait_n(1);
    check("R1", "second trial", int'(dac_code), (v & 512) | 256);
    wait_n(8);
    check("R2", "start bit before last edge", int'(ctl_rdata[0]), 1);
    check("R6", "done before last edge", int'(ctl_rdata[1]), 0);
    wait_n(1);
    exp_data[ch] = RES'(v);
    check("R2", "start bit after completion", int'(ctl_rdata[0]), 0);
    check("R6", "done after completion", int'(ctl_rdata[1]), 1);
    check("R7", "irq with enable off", int'(irq), 0);
    check_all_data("R4_R5");
    wait_n(15);
    check("R3", "dac idle after single", int'(dac_code), 0);
    check("R3", "stays idle", int'(ctl_rdata[0]), 0);
    ctl_write(CTLW'(ch << 4));
    check("R6", "done cleared by write 0", int'(ctl_rdata[1]), 0);
  endtask

  task automatic t_trigger(input int ch, input int v);
    ctl_write(CTLW'(ch << 4));
    vin = RES'(v);
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    check("R2", "start bit after trigger", int'(ctl_rdata[0]), 1);
    wait_n(11);
    exp_data[ch] = RES'(v);
    check("R2", "trigger conversion done", int'(ctl_rdata[1]), 1);
    check_all_data("R4");
    ctl_write(CTLW'(ch << 4));
  endtask

  task automatic t_collision;
    vin = 10'd777;
    ctl_write(6'h31);
    wait_n(10);
    ctl_write(6'h04);  // clears done, irq enable on, start 0: lands on completion edge
    exp_data[3] = 10'd777;
    check("R6", "done kept on collision", int'(ctl_rdata[1]), 1);
    check("R7", "irq on collision", int'(irq), 1);
    check("R8", "completion not aborted", int'(ctl_rdata[0]), 0);
    check_all_data("R4");
    ctl_write(6'h02);
    check("R6", "writing 1 to done keeps it", int'(ctl_rdata[1]), 1);
    check("R7", "irq off with enable off", int'(irq), 0);
    ctl_write(6'h06);
    check("R7", "irq back with enable on", int'(irq), 1);
    ctl_write(6'h04);
    check("R7", "irq off after clear", int'(irq), 0);
    check("R6", "done cleared", int'(ctl_rdata[1]), 0);
  endtask

  task automatic t_abort;
    vin = 10'd300;
    ctl_write(6'h21);
    wait_n(4);
    ctl_write(6'h20);
    check("R8", "start bit after abort", int'(ctl_rdata[0]), 0);
    wait_n(14);
    check("R8", "no done after abort", int'(ctl_rdata[1]), 0);
    check("R8", "dac idle after abort", int'(dac_code), 0);
    check_all_data("R8");
  endtask

  task automatic t_busy_ignore;
    vin = 10'd5;
    ctl_write(6'h11);
    wait_n(2);
    ctl_write(6'h29);  // channel 2 + mode + start while busy
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    check("R9", "channel field frozen", int'(ctl_rdata[5:4]), 1);
    wait_n(7);
    exp_data[1] = 10'd5;
    check("R9", "done for original channel", int'(ctl_rdata[1]), 1);
    check_all_data("R9");
    wait_n(15);
    check("R9", "no second conversion", int'(ctl_rdata[0]), 0);
    ctl_write(6'h10);
  endtask

  task automatic t_mode;
    ctl_write(6'h08);
    check("R10", "mode bit reads 0", int'(ctl_rdata[3]), 0);
    check("R10", "nothing started", int'(ctl_rdata[0]), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int c = 0; c < NCH; c++) exp_data[c] = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_single(1, 1023);
    t_single(0, 0);
    t_single(2, 341);
    t_single(3, 512);
    t_trigger(0, 682);
    t_collision();
    t_abort();
    t_busy_ignore();
    t_mode();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule